// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Controller

This block decides, cycle by cycle, whether the front of an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback) may advance. It also decides whether each execute-stage operand should take the value sitting in the memory/writeback latch instead of the one read from the register file. The decode stage presents the instruction it holds as a valid bit, an operation kind and three register fields. The block keeps its own shadow of the register fields that travel down the pipe, so the datapath only has to apply the controls it emits.

The only bypass source is the memory/writeback latch. A value produced by the instruction directly ahead therefore cannot reach a dependent instruction in time. Any such back-to-back read-after-write costs exactly one stall cycle, whether the producer is an ALU operation or a load. When the producer is two instructions ahead, the value is bypassed. When it is three ahead, the register file supplies it: the file is written in the first half of a cycle and read in the second half. Write-after-read and write-after-write orderings cannot go wrong in this pipe and raise nothing. Register 0 always reads zero and never takes part in a dependence.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after reset, the pipe shadow is empty: no stall control and no bypass select is raised, whatever decode presents.
- R2: When a valid decode instruction uses a source register equal to the nonzero destination of a writing instruction in execute, pc_hold, ifid_hold and idex_bubble are all 1 in that cycle.
- R3: A stall lasts exactly one cycle when decode is held. The inserted bubble writes nothing, so it causes no stall and no bypass.
- R4: A bypass select is raised independently for each operand: ex_sel_a for the first source and ex_sel_b for the second. Each is raised when that used source of the execute instruction equals the destination of a writing instruction in the memory/writeback latch. Both may be 1 together.
- R5: A dependence on the instruction two ahead causes no stall. It is served by a bypass select in the following cycle.
- R6: A dependence on the instruction three ahead causes neither a stall nor a bypass.
- R7: Register 0 as a destination or as a source never causes a stall or a bypass.
- R8: Kind encoding (id_kind): 0 no-op (no sources, no write); 1 reg-reg ALU (first and second source, writes); 2 reg-immediate ALU (first source, writes); 3 load (first source as base, writes); 4 store (both sources, no write); 5 branch (both sources, no write); 6 upper-immediate (no sources, writes); 7 treated as no-op. Unused source fields and the destination field of a non-writing kind are ignored.
- R9: Write-after-read and write-after-write orderings raise neither a stall nor a bypass.
- R10: When id_valid is 0 the decode slot reads nothing and cannot stall.
- R11: A store stalls on a dependence through either its base (first source) or its data (second source) register.
- R12: A load producer is interlocked exactly like an ALU producer: one stall, then a bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_kind | input | 3 | Operation kind of the decode instruction (R8 encoding) |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_rd | input | REG_W | Destination register of the decode instruction |
| pc_hold | output | 1 | Keep the program counter this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode latch this cycle |
| idex_bubble | output | 1 | Load a bubble into the decode/execute latch this cycle |
| ex_sel_a | output | 1 | First execute operand takes the memory/writeback value |
| ex_sel_b | output | 1 | Second execute operand takes the memory/writeback value |

## Verification
The hardest situation to reach is the cycle, two edges after a stall, in which the held consumer has finally entered execute and its producer has moved into the memory/writeback latch. Only there does a stall turn into a bypass. The stimulus reaches it by presenting the same decode instruction again for as long as the hold is raised, as the held fetch/decode latch would. It then presents a no-op so that the consumer sits in execute while the select is sampled. Distance-two and distance-three producers are reached by spacing producer and consumer with unrelated instructions or no-ops, with no-ops between scenarios so that nothing earlier lingers in the shadow.

// File: rtl/phc_pkg.sv
// Shared types for the pipeline hazard controller.
// Assumes a 3-bit operation kind field supplied by the decode stage.
package phc_pkg;

    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_ALU_RR = 3'd1,
        K_ALU_RI = 3'd2,
        K_LOAD   = 3'd3,
        K_STORE  = 3'd4,
        K_BRANCH = 3'd5,
        K_UPPER  = 3'd6,
        K_RSVD   = 3'd7
    } op_kind_e;

    // Which register fields an instruction actually uses.
    typedef struct packed {
        logic rd_a;   // reads first source
        logic rd_b;   // reads second source
        logic wr;     // writes destination
    } op_use_t;

endpackage

// File: rtl/phc_decode.sv
// Operand-usage decoder: maps the operation kind to the set of register
// fields the instruction reads and writes. An invalid slot uses nothing.
// Assumes the kind encoding of phc_pkg::op_kind_e.
module phc_decode
    import phc_pkg::*;
(
    input  logic    valid,
    input  logic [2:0] kind,
    output op_use_t use_o
);

    // Purpose: table of source/destination usage per kind.
    always_comb begin
        use_o = '0;
        if (valid) begin
            case (op_kind_e'(kind))
                K_ALU_RR: use_o = '{rd_a: 1'b1, rd_b: 1'b1, wr: 1'b1};
                K_ALU_RI: use_o = '{rd_a: 1'b1, rd_b: 1'b0, wr: 1'b1};
                K_LOAD:   use_o = '{rd_a: 1'b1, rd_b: 1'b0, wr: 1'b1};
                K_STORE:  use_o = '{rd_a: 1'b1, rd_b: 1'b1, wr: 1'b0};
                K_BRANCH: use_o = '{rd_a: 1'b1, rd_b: 1'b1, wr: 1'b0};
                K_UPPER:  use_o = '{rd_a: 1'b0, rd_b: 1'b0, wr: 1'b1};
                default:  use_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/phc_shadow.sv
// Register-field shadow of the decode/execute, execute/memory and
// memory/writeback latches. Advances every cycle; on a stall the
// execute slot is loaded with an empty bubble instead of the decode
// instruction. Assumes the datapath never freezes the back of the pipe.
module phc_shadow
    import phc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  op_use_t          id_use,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] id_rd,
    output op_use_t          ex_use,
    output logic [REG_W-1:0] ex_rs1,
    output logic [REG_W-1:0] ex_rs2,
    output logic [REG_W-1:0] ex_rd,
    output logic             wb_wr,
    output logic [REG_W-1:0] wb_rd
);

    logic             mem_wr;
    logic [REG_W-1:0] mem_rd;

    // Purpose: decode -> execute, with a bubble when stalled.
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            ex_use <= '0;
            ex_rs1 <= '0;
            ex_rs2 <= '0;
            ex_rd  <= '0;
        end else begin
            ex_use <= id_use;
            ex_rs1 <= id_rs1;
            ex_rs2 <= id_rs2;
            ex_rd  <= id_rd;
        end
    end

    // Purpose: carry the destination from execute to memory to writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr <= 1'b0;
            mem_rd <= '0;
            wb_wr  <= 1'b0;
            wb_rd  <= '0;
        end else begin
            mem_wr <= ex_use.wr;
            mem_rd <= ex_rd;
            wb_wr  <= mem_wr;
            wb_rd  <= mem_rd;
        end
    end

endmodule

// File: rtl/phc_match.sv
// Single source/destination comparator: hit when the source is used,
// the producer writes, both name the same register and it is not the
// hardwired zero register.
module phc_match #(
    parameter int REG_W = 5
) (
    input  logic             src_used,
    input  logic             dst_wr,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);

    // Purpose: qualified register-number equality.
    always_comb begin
        hit = src_used && dst_wr && (src == dst) && (src != '0);
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard and bypass controller for an in-order five-stage pipeline whose
// only bypass source is the memory/writeback latch. Decode sources are
// compared with the execute destination to interlock; execute sources
// are compared with the writeback destination to steer the operand muxes.
// Assumes the register file writes before it reads within a cycle.
module pipe_hazard_ctrl
    import phc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [2:0]       id_kind,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] id_rd,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ex_sel_a,
    output logic             ex_sel_b
);

    localparam int NSRC = 2;

    op_use_t          id_use;
    op_use_t          ex_use;
    logic [REG_W-1:0] ex_rs1;
    logic [REG_W-1:0] ex_rs2;
    logic [REG_W-1:0] ex_rd;
    logic             wb_wr;
    logic [REG_W-1:0] wb_rd;
    logic             stall;

    logic [NSRC-1:0][REG_W-1:0] id_src;
    logic [NSRC-1:0][REG_W-1:0] ex_src;
    logic [NSRC-1:0]            id_src_used;
    logic [NSRC-1:0]            ex_src_used;
    logic [NSRC-1:0]            stall_hit;
    logic [NSRC-1:0]            fwd_hit;

    phc_decode u_dec (
        .valid (id_valid),
        .kind  (id_kind),
        .use_o (id_use)
    );

    phc_shadow #(.REG_W(REG_W)) u_shd (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .id_use (id_use),
        .id_rs1 (id_rs1),
        .id_rs2 (id_rs2),
        .id_rd  (id_rd),
        .ex_use (ex_use),
        .ex_rs1 (ex_rs1),
        .ex_rs2 (ex_rs2),
        .ex_rd  (ex_rd),
        .wb_wr  (wb_wr),
        .wb_rd  (wb_rd)
    );

    // Purpose: gather per-operand source fields and usage bits.
    always_comb begin
        id_src      = {id_rs2, id_rs1};
        ex_src      = {ex_rs2, ex_rs1};
        id_src_used = {id_use.rd_b, id_use.rd_a};
        ex_src_used = {ex_use.rd_b, ex_use.rd_a};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        phc_match #(.REG_W(REG_W)) u_stall_cmp (
            .src_used (id_src_used[g]),
            .dst_wr   (ex_use.wr),
            .src      (id_src[g]),
            .dst      (ex_rd),
            .hit      (stall_hit[g])
        );
        phc_match #(.REG_W(REG_W)) u_fwd_cmp (
            .src_used (ex_src_used[g]),
            .dst_wr   (wb_wr),
            .src      (ex_src[g]),
            .dst      (wb_rd),
            .hit      (fwd_hit[g])
        );
    end

    // Purpose: combine comparator hits into pipeline controls.
    always_comb begin
        stall       = |stall_hit;
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
        ex_sel_a    = fwd_hit[0];
        ex_sel_b    = fwd_hit[1];
    end

endmodule

// File: rtl/phc_checker.sv
// Protocol checker for pipe_hazard_ctrl, bound to every instance.
// Assumes the environment keeps the decode inputs steady while a hold
// is raised, as the held fetch/decode latch does.
module phc_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic [REG_W-1:0] id_rs1,
    input logic [REG_W-1:0] id_rs2,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             ex_sel_a,
    input logic             ex_sel_b
);

    logic [1:0] age;

    // Purpose: count clean cycles since reset so history checks are valid.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && idex_bubble) |=> !idex_bubble);

    p_stall_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> id_valid);

    p_zero_sources_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0 && id_rs2 == '0) |-> !pc_hold);

    p_bubble_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && idex_bubble) |=> (!ex_sel_a && !ex_sel_b));

    p_stall_then_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(idex_bubble, 2)) |-> (ex_sel_a || ex_sel_b));

    p_hold_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $rose(ifid_hold)) |-> $past(!idex_bubble));

endmodule

bind pipe_hazard_ctrl phc_checker #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ex_sel_a    (ex_sel_a),
    .ex_sel_b    (ex_sel_b)
);

// File: tb/sim_pipe_hazard_ctrl.sv
// Directed bench for pipe_hazard_ctrl: one task per scenario.
module sim_pipe_hazard_ctrl;

    localparam int REG_W = 5;
    localparam logic [2:0] NOP = 3'd0, RR = 3'd1, RI = 3'd2, LD = 3'd3,
                           ST = 3'd4, BR = 3'd5, UP = 3'd6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             id_valid = 1'b0;
    logic [2:0]       id_kind = NOP;
    logic [REG_W-1:0] id_rs1 = '0;
    logic [REG_W-1:0] id_rs2 = '0;
    logic [REG_W-1:0] id_rd = '0;
    logic             pc_hold, ifid_hold, idex_bubble, ex_sel_a, ex_sel_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pipe_hazard_ctrl #(.REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_kind(id_kind),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
    );

    // Drive decode at the falling edge, check mid-cycle, then pass the rising edge.
    task automatic cyc(input logic v, input logic [2:0] k,
                       input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                       input logic [REG_W-1:0] d,
                       input logic es, input logic ea, input logic eb,
                       input string tag);
        @(negedge clk);
        id_valid = v; id_kind = k; id_rs1 = a; id_rs2 = b; id_rd = d;
        #1;
        n_chk++;
        if (pc_hold !== es || ifid_hold !== es || idex_bubble !== es ||
            ex_sel_a !== ea || ex_sel_b !== eb) begin
            n_bad++;
            $display("FAIL %s: hold/ifid/bubble/selA/selB = %b%b%b/%b/%b expected %b%b%b/%b/%b",
                     tag, pc_hold, ifid_hold, idex_bubble, ex_sel_a, ex_sel_b,
                     es, es, es, ea, eb);
        end
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            id_valid = 1'b0; id_kind = NOP; id_rs1 = '0; id_rs2 = '0; id_rd = '0;
        end
    endtask

    task automatic t_reset();
        cyc(1, RR, 5'd3, 5'd4, 5'd5, 0, 0, 0, "R1 during reset");
        cyc(1, RR, 5'd5, 5'd5, 5'd6, 0, 0, 0, "R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        cyc(1, RR, 5'd3, 5'd4, 5'd7, 0, 0, 0, "R1 first cycle");
        flush();
    endtask

    task automatic t_alu_back();
        cyc(1, RR, 5'd2, 5'd3, 5'd1, 0, 0, 0, "R2 producer");
        cyc(1, RR, 5'd1, 5'd4, 5'd5, 1, 0, 0, "R2 stall");
        cyc(1, RR, 5'd1, 5'd4, 5'd5, 0, 0, 0, "R3 single stall");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 1, 0, "R4 bypass a");
        flush();
    endtask

    task automatic t_load();
        cyc(1, LD, 5'd2, 5'd0, 5'd6, 0, 0, 0, "R12 load");
        cyc(1, RR, 5'd4, 5'd6, 5'd7, 1, 0, 0, "R12 stall");
        cyc(1, RR, 5'd4, 5'd6, 5'd7, 0, 0, 0, "R12 release");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 1, "R12 bypass b");
        flush();
    endtask

    task automatic t_dist2();
        cyc(1, RR, 5'd2, 5'd3, 5'd8, 0, 0, 0, "R5 producer");
        cyc(1, RR, 5'd9, 5'd10, 5'd11, 0, 0, 0, "R5 filler");
        cyc(1, RR, 5'd8, 5'd12, 5'd13, 0, 0, 0, "R5 no stall");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 1, 0, "R5 bypass");
        flush();
    endtask

    task automatic t_dist3();
        cyc(1, RR, 5'd2, 5'd3, 5'd14, 0, 0, 0, "R6 producer");
        cyc(0, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R6 gap");
        cyc(0, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R6 gap");
        cyc(1, RR, 5'd14, 5'd14, 5'd15, 0, 0, 0, "R6 no stall");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R6 no bypass");
        flush();
    endtask

    task automatic t_both();
        cyc(1, RR, 5'd2, 5'd3, 5'd16, 0, 0, 0, "R4 producer");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R4 gap");
        cyc(1, RR, 5'd16, 5'd16, 5'd17, 0, 0, 0, "R4 consumer");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 1, 1, "R4 both operands");
        flush();
    endtask

    task automatic t_zero();
        cyc(1, RR, 5'd2, 5'd3, 5'd0, 0, 0, 0, "R7 write r0");
        cyc(1, RR, 5'd0, 5'd0, 5'd18, 0, 0, 0, "R7 no stall on r0");
        flush();
        cyc(1, UP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R7 write r0");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R7 gap");
        cyc(1, RR, 5'd0, 5'd0, 5'd19, 0, 0, 0, "R7 consumer");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R7 no bypass on r0");
        flush();
    endtask

    task automatic t_store();
        cyc(1, RR, 5'd2, 5'd3, 5'd20, 0, 0, 0, "R11 producer");
        cyc(1, ST, 5'd21, 5'd20, 5'd0, 1, 0, 0, "R11 data stall");
        cyc(1, ST, 5'd21, 5'd20, 5'd0, 0, 0, 0, "R11 release");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 1, "R11 data bypass");
        flush();
        cyc(1, RR, 5'd2, 5'd3, 5'd22, 0, 0, 0, "R11 producer");
        cyc(1, ST, 5'd22, 5'd3, 5'd0, 1, 0, 0, "R11 base stall");
        cyc(1, ST, 5'd22, 5'd3, 5'd0, 0, 0, 0, "R11 release");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 1, 0, "R11 base bypass");
        flush();
    endtask

    task automatic t_order();
        cyc(1, RR, 5'd4, 5'd5, 5'd23, 0, 0, 0, "R9 first write");
        cyc(1, RR, 5'd6, 5'd7, 5'd23, 0, 0, 0, "R9 WAW no stall");
        flush();
        cyc(1, RR, 5'd24, 5'd25, 5'd26, 0, 0, 0, "R9 reader");
        cyc(1, RR, 5'd2, 5'd3, 5'd24, 0, 0, 0, "R9 WAR no stall");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R9 no bypass");
        flush();
    endtask

    task automatic t_usage();
        cyc(1, RR, 5'd2, 5'd3, 5'd27, 0, 0, 0, "R8 producer");
        cyc(1, RI, 5'd2, 5'd27, 5'd28, 0, 0, 0, "R8 unused rs2");
        flush();
        cyc(1, BR, 5'd2, 5'd3, 5'd29, 0, 0, 0, "R8 branch rd field");
        cyc(1, RR, 5'd29, 5'd29, 5'd1, 0, 0, 0, "R8 branch writes nothing");
        flush();
        cyc(1, ST, 5'd2, 5'd3, 5'd30, 0, 0, 0, "R8 store rd field");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R8 gap");
        cyc(1, RR, 5'd30, 5'd30, 5'd1, 0, 0, 0, "R8 consumer");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R8 store no bypass");
        flush();
        cyc(1, UP, 5'd0, 5'd0, 5'd31, 0, 0, 0, "R8 upper writes");
        cyc(1, NOP, 5'd31, 5'd31, 5'd0, 0, 0, 0, "R8 no-op reads nothing");
        flush();
        cyc(1, UP, 5'd0, 5'd0, 5'd31, 0, 0, 0, "R8 upper writes");
        cyc(1, RR, 5'd31, 5'd0, 5'd2, 1, 0, 0, "R8 upper stall");
        cyc(1, RR, 5'd31, 5'd0, 5'd2, 0, 0, 0, "R8 release");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 1, 0, "R8 upper bypass");
        flush();
    endtask

    task automatic t_invalid();
        cyc(1, RR, 5'd2, 5'd3, 5'd5, 0, 0, 0, "R10 producer");
        cyc(0, RR, 5'd5, 5'd5, 5'd6, 0, 0, 0, "R10 invalid no stall");
        cyc(1, NOP, 5'd0, 5'd0, 5'd0, 0, 0, 0, "R10 no bypass");
        flush();
    endtask

    initial begin
        t_reset();
        t_alu_back();
        t_load();
        t_dist2();
        t_dist3();
        t_both();
        t_zero();
        t_store();
        t_order();
        t_usage();
        t_invalid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule